// File: doc/BRIEF.md
# Branch Target Prediction Table

This block is the next-PC predictor for the second fetch stage. Each cycle it takes the PC that the next-PC logic produced and searches a small fully associative table of recently taken branches. When a valid entry holds that PC and its two-bit confidence counter leans toward taken, the block offers the stored target as the next fetch address. Otherwise it offers the sequential address. A branch that the table has never seen is therefore always predicted not-taken.

The first execute stage sends one report per resolved branch. The report gives the branch PC, the real direction, the real target, and the next PC that was predicted for it. When the real next PC differs from the prediction, the block raises a one-cycle flush with the correct PC on the following cycle. In the same cycle it trains the entry: it moves the counter, rewrites the target, or claims a new slot for a taken branch that missed. Slots are handed out by a round-robin pointer. If a report and a lookup name the same PC in the same cycle, the lookup sees the table after the update.

Top module: `btb_table`

## Requirements
- R1: Reset invalidates every entry and returns the allocation pointer to slot 0. After reset every lookup misses and `flush` is low.
- R2: A lookup hits when a valid entry holds exactly `lk_pc`. On a hit with counter code 2 or 3, `pred_taken` is 1 and `pred_npc` is the stored target.
- R3: On a miss, or on a hit with counter code 0 or 1, `pred_taken` is 0 and `pred_npc` is `lk_pc + STEP`. `pred_hit` is 0 on a miss.
- R4: The counter codes are 0 strong not-taken, 1 weak not-taken, 2 weak taken and 3 strong taken. A resolved taken branch that hits raises the code by one and stops at 3. A resolved not-taken branch that hits lowers it by one and stops at 0.
- R5: A new entry is created only for a resolved taken branch with no entry. It stores the branch PC and target and starts at code 2. A not-taken branch with no entry leaves the table unchanged.
- R6: New entries go to the slot named by a pointer that starts at 0, moves up one per allocation and wraps after the last slot. An allocation therefore evicts the oldest allocated entry once the table is full.
- R7: A resolved taken branch that hits replaces the stored target with the reported one.
- R8: A report is a misprediction when its real next PC differs from `rs_pred_npc`. The real next PC is `rs_target` if taken and `rs_pc + STEP` if not. On the cycle after a misprediction, `flush` is 1 and `redirect_pc` is the real next PC.
- R9: On the cycle after a correctly predicted report, or after a cycle with no report, `flush` is 0.
- R10: When a report and a lookup name the same PC in one cycle, the lookup result reflects the table after that report's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC to look up (second fetch stage) |
| pred_hit | output | 1 | A valid entry matches `lk_pc` |
| pred_taken | output | 1 | Prediction is taken |
| pred_npc | output | PC_W | Predicted next fetch PC |
| rs_valid | input | 1 | A resolved branch report is present |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_taken | input | 1 | Real direction of the branch |
| rs_target | input | PC_W | Real taken target |
| rs_pred_npc | input | PC_W | Next PC that was predicted for this branch |
| flush | output | 1 | One-cycle squash of younger fetches |
| redirect_pc | output | PC_W | Corrected fetch PC, meaningful while `flush` is 1 |

## Verification
The assertions check, every cycle, the properties that need no history. At most one slot matches a lookup. A miss falls through to the sequential PC and is never taken. A taken report for the PC being looked up always produces a hit. Any flush follows a report, and after a taken report it carries that report's target. What only the bench's scenarios can show depends on the table's contents over time: the counter stepping and saturating, allocation only on taken misses, round-robin eviction of the oldest slot, and target rewrites. The bench shows these by comparing every cycle against an independent behavioural model of the table.

// File: rtl/btb_pkg.sv
package btb_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'd0,
      CTR_WEAK_NT   = 2'd1,
      CTR_WEAK_TK   = 2'd2,
      CTR_STRONG_TK = 2'd3
   } ctr_t;

   // saturating step of the confidence counter
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t res;
      res = cur;
      if (taken) begin
         if (cur != CTR_STRONG_TK) res = ctr_t'(cur + 2'd1);
      end else begin
         if (cur != CTR_STRONG_NT) res = ctr_t'(cur - 2'd1);
      end
      return res;
   endfunction

   function automatic logic ctr_says_taken(input ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/btb_entry.sv
module btb_entry
   import btb_pkg::*;
#(
   parameter int PC_W = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_en,
   input  logic            upd_en,
   input  logic            taken,
   input  logic [PC_W-1:0] pc_in,
   input  logic [PC_W-1:0] tgt_in,
   output logic            valid_q,
   output logic [PC_W-1:0] pc_q,
   output logic [PC_W-1:0] tgt_q,
   output ctr_t            st_q,
   output logic            valid_n,
   output logic [PC_W-1:0] pc_n,
   output logic [PC_W-1:0] tgt_n,
   output ctr_t            st_n
);

   always_comb begin
      valid_n = valid_q;
      pc_n    = pc_q;
      tgt_n   = tgt_q;
      st_n    = st_q;
      if (alloc_en) begin
         valid_n = 1'b1;
         pc_n    = pc_in;
         tgt_n   = tgt_in;
         st_n    = CTR_WEAK_TK;
      end else if (upd_en) begin
         st_n = ctr_step(st_q, taken);
         if (taken) tgt_n = tgt_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pc_q    <= '0;
         tgt_q   <= '0;
         st_q    <= CTR_STRONG_NT;
      end else begin
         valid_q <= valid_n;
         pc_q    <= pc_n;
         tgt_q   <= tgt_n;
         st_q    <= st_n;
      end
   end

endmodule

// File: rtl/btb_match.sv
module btb_match #(
   parameter int ENTRIES = 16,
   parameter int PC_W    = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
)(
   input  logic [ENTRIES-1:0]           valid,
   input  logic [ENTRIES-1:0][PC_W-1:0] pcs,
   input  logic [PC_W-1:0]              key,
   output logic [ENTRIES-1:0]           hit_vec,
   output logic                         any_hit,
   output logic [IDX_W-1:0]             hit_idx
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (pcs[g] == key);
   end

   assign any_hit = |hit_vec;

   // lowest matching slot wins
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/btb_table.sv
module btb_table
   import btb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PC_W    = 32,
   parameter int STEP    = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_npc,
   input  logic            rs_valid,
   input  logic [PC_W-1:0] rs_pc,
   input  logic            rs_taken,
   input  logic [PC_W-1:0] rs_target,
   input  logic [PC_W-1:0] rs_pred_npc,
   output logic            flush,
   output logic [PC_W-1:0] redirect_pc
);

   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("btb_table: ENTRIES must be a power of two of at least 2");
   end
   if (STEP < 1 || PC_W < 2) begin : g_bad_step
      $error("btb_table: STEP and PC_W out of range");
   end

   logic [ENTRIES-1:0]           e_valid_q, e_valid_n;
   logic [ENTRIES-1:0][PC_W-1:0] e_pc_q, e_pc_n, e_tgt_q, e_tgt_n;
   ctr_t [ENTRIES-1:0]           e_st_q, e_st_n;

   logic [ENTRIES-1:0] rs_hit_vec;
   logic               rs_hit;
   logic [IDX_W-1:0]   rs_idx;
   logic [ENTRIES-1:0] lk_hit_vec;
   logic               lk_hit;
   logic [IDX_W-1:0]   lk_idx;

   logic [IDX_W-1:0]   rr_q;
   logic               alloc_go;

   // update side works on the registered table
   btb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_rs_match (
      .valid   (e_valid_q),
      .pcs     (e_pc_q),
      .key     (rs_pc),
      .hit_vec (rs_hit_vec),
      .any_hit (rs_hit),
      .hit_idx (rs_idx)
   );

   assign alloc_go = rs_valid && rs_taken && !rs_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)        rr_q <= '0;
      else if (alloc_go) rr_q <= rr_q + 1'b1;
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      btb_entry #(.PC_W(PC_W)) u_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc_en (alloc_go && (rr_q == IDX_W'(g))),
         .upd_en   (rs_valid && rs_hit_vec[g]),
         .taken    (rs_taken),
         .pc_in    (rs_pc),
         .tgt_in   (rs_target),
         .valid_q  (e_valid_q[g]),
         .pc_q     (e_pc_q[g]),
         .tgt_q    (e_tgt_q[g]),
         .st_q     (e_st_q[g]),
         .valid_n  (e_valid_n[g]),
         .pc_n     (e_pc_n[g]),
         .tgt_n    (e_tgt_n[g]),
         .st_n     (e_st_n[g])
      );
   end

   // lookup side sees the post-update table (update first)
   btb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_lk_match (
      .valid   (e_valid_n),
      .pcs     (e_pc_n),
      .key     (lk_pc),
      .hit_vec (lk_hit_vec),
      .any_hit (lk_hit),
      .hit_idx (lk_idx)
   );

   assign pred_hit   = lk_hit;
   assign pred_taken = lk_hit && ctr_says_taken(e_st_n[lk_idx]);
   assign pred_npc   = pred_taken ? e_tgt_n[lk_idx] : (lk_pc + STEP_V);

   logic [PC_W-1:0] real_npc;
   logic            mispredict;

   assign real_npc   = rs_taken ? rs_target : (rs_pc + STEP_V);
   assign mispredict = rs_valid && (real_npc != rs_pred_npc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush       <= 1'b0;
         redirect_pc <= '0;
      end else begin
         flush <= mispredict;
         if (mispredict) redirect_pc <= real_npc;
      end
   end

endmodule

// File: rtl/btb_table_chk.sv
module btb_table_chk #(
   parameter int ENTRIES = 16,
   parameter int PC_W    = 32,
   parameter int STEP    = 4
)(
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    lk_pc,
   input logic               pred_hit,
   input logic               pred_taken,
   input logic [PC_W-1:0]    pred_npc,
   input logic               rs_valid,
   input logic [PC_W-1:0]    rs_pc,
   input logic               rs_taken,
   input logic [PC_W-1:0]    rs_target,
   input logic               flush,
   input logic [PC_W-1:0]    redirect_pc,
   input logic [ENTRIES-1:0] lk_hit_vec
);

   assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_vec));

   assert_miss_falls_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> (!pred_taken && pred_npc == lk_pc + PC_W'(STEP)));

   assert_taken_needs_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> pred_hit);

   assert_update_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && rs_taken && rs_pc == lk_pc) |-> pred_hit);

   assert_flush_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> $past(rs_valid));

   assert_redirect_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && $past(rs_taken)) |-> redirect_pc == $past(rs_target));

endmodule

bind btb_table btb_table_chk #(.ENTRIES(ENTRIES), .PC_W(PC_W), .STEP(STEP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_pc       (lk_pc),
   .pred_hit    (pred_hit),
   .pred_taken  (pred_taken),
   .pred_npc    (pred_npc),
   .rs_valid    (rs_valid),
   .rs_pc       (rs_pc),
   .rs_taken    (rs_taken),
   .rs_target   (rs_target),
   .flush       (flush),
   .redirect_pc (redirect_pc),
   .lk_hit_vec  (lk_hit_vec)
);

// File: tb/sim_btb_table.sv
module sim_btb_table;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        pred_hit, pred_taken;
   logic [31:0] pred_npc;
   logic        rs_valid = 1'b0;
   logic [31:0] rs_pc = '0;
   logic        rs_taken = 1'b0;
   logic [31:0] rs_target = '0;
   logic [31:0] rs_pred_npc = '0;
   logic        flush;
   logic [31:0] redirect_pc;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   btb_table #(.ENTRIES(N), .PC_W(32), .STEP(4)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
      .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_npc(pred_npc),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
      .rs_target(rs_target), .rs_pred_npc(rs_pred_npc),
      .flush(flush), .redirect_pc(redirect_pc)
   );

   // behavioural model of the table
   bit          m_valid[N];
   logic [31:0] m_pc[N];
   logic [31:0] m_tgt[N];
   int          m_st[N];
   int          m_rr;
   bit          exp_flush;
   logic [31:0] exp_red;

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 0; m_pc[i] = '0; m_tgt[i] = '0; m_st[i] = 0;
      end
      m_rr = 0;
      exp_flush = 0;
      exp_red = '0;
   endtask

   function automatic int find(input logic [31:0] pc);
      for (int i = 0; i < N; i++) if (m_valid[i] && m_pc[i] == pc) return i;
      return -1;
   endfunction

   function automatic logic [31:0] mpred(input logic [31:0] pc);
      int h;
      h = find(pc);
      if (h >= 0 && m_st[h] >= 2) return m_tgt[h];
      return pc + 32'd4;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // one clock: drive, check against the model, advance the model
   task automatic cyc(input bit rv, input logic [31:0] rpc, input bit rt,
                      input logic [31:0] rtgt, input logic [31:0] rpn,
                      input logic [31:0] lpc, input string req);
      int h;
      logic [31:0] actual;
      bit eh, et;
      logic [31:0] en;
      @(negedge clk);
      rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_target = rtgt;
      rs_pred_npc = rpn; lk_pc = lpc;
      #1;
      chk(flush == exp_flush, exp_flush ? "R8" : "R9", "flush", 32'(flush), 32'(exp_flush));
      if (exp_flush) chk(redirect_pc == exp_red, "R8", "redirect_pc", redirect_pc, exp_red);
      if (rv) begin
         h = find(rpc);
         if (h >= 0) begin
            if (rt) begin
               if (m_st[h] < 3) m_st[h]++;
               m_tgt[h] = rtgt;
            end else if (m_st[h] > 0) m_st[h]--;
         end else if (rt) begin
            m_valid[m_rr] = 1; m_pc[m_rr] = rpc; m_tgt[m_rr] = rtgt; m_st[m_rr] = 2;
            m_rr = (m_rr + 1) % N;
         end
      end
      actual = rt ? rtgt : rpc + 32'd4;
      exp_flush = rv && (actual != rpn);
      if (exp_flush) exp_red = actual;
      h = find(lpc);
      eh = (h >= 0);
      et = eh && m_st[h] >= 2;
      en = et ? m_tgt[h] : lpc + 32'd4;
      chk(pred_hit == eh, req, "pred_hit", 32'(pred_hit), 32'(eh));
      chk(pred_taken == et, req, "pred_taken", 32'(pred_taken), 32'(et));
      chk(pred_npc == en, req, "pred_npc", pred_npc, en);
   endtask

   task automatic idle(input logic [31:0] lpc, input string req);
      cyc(0, 32'h0, 0, 32'h0, 32'h0, lpc, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; rs_valid = 0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1;
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   localparam logic [31:0] A = 32'h0000_0100;
   localparam logic [31:0] B = 32'h0000_0300;

   initial begin
      model_reset();
      do_reset();
      // R1: empty table after reset
      idle(A, "R1");
      idle(32'h0, "R1");
      // R5: first taken resolution, predicted not-taken, allocates; R3 miss elsewhere
      cyc(1, A, 1, 32'h400, A + 4, 32'h200, "R3");
      // R2: entry now predicts taken (also checks R8 flush for the previous report)
      idle(A, "R2");
      // R10: not-taken update and lookup of the same PC in one cycle
      cyc(1, A, 0, 32'h400, 32'h400, A, "R10");
      idle(A, "R4");
      // R4: climb and saturate, then one not-taken stays on taken side
      cyc(1, A, 1, 32'h400, mpred(A), 32'h0, "R4");
      cyc(1, A, 1, 32'h400, mpred(A), A, "R4");
      cyc(1, A, 1, 32'h400, mpred(A), A, "R4");
      cyc(1, A, 0, 32'h400, mpred(A), A, "R4");
      cyc(1, A, 0, 32'h400, mpred(A), A, "R4");
      cyc(1, A, 0, 32'h400, mpred(A), A, "R4");
      cyc(1, A, 0, 32'h400, mpred(A), A, "R4");
      cyc(1, A, 1, 32'h400, mpred(A), A, "R4");
      cyc(1, A, 1, 32'h400, mpred(A), A, "R4");
      // R5/R9: unseen not-taken branch, correct prediction, no allocation
      cyc(1, B, 0, 32'h900, B + 4, B, "R5");
      idle(B, "R9");
      // R7: taken with a new target, same-cycle lookup sees it
      cyc(1, A, 1, 32'h800, 32'h400, A, "R7");
      idle(A, "R7");
      // R6: fill the table; the 16th allocation evicts A in slot 0
      for (int i = 0; i < N; i++) begin
         cyc(1, 32'h1000 + 32'(8 * i), 1, 32'h2000 + 32'(i),
             32'h1004 + 32'(8 * i), (i == N - 2) ? A : 32'h1000, "R6");
      end
      idle(A, "R6");
      idle(32'h1000 + 32'(8 * (N - 1)), "R6");
      idle(32'h1008, "R6");
      // mixed traffic against the model
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] p, l, t, pn;
         bit v, tk;
         p  = 32'h4000 + 32'(4 * $urandom_range(0, 23));
         l  = ($urandom_range(0, 3) == 0) ? p : 32'h4000 + 32'(4 * $urandom_range(0, 23));
         t  = 32'h6000 + 32'(4 * $urandom_range(0, 3));
         v  = $urandom_range(0, 3) != 0;
         tk = $urandom_range(0, 2) != 0;
         pn = ($urandom_range(0, 9) == 0) ? 32'h0 : mpred(p);
         cyc(v, p, tk, t, pn, l, "R4");
      end
      // R1: reset mid-run clears learned entries
      do_reset();
      idle(32'h1008, "R1");
      idle(32'h4000, "R1");
      idle(32'h4004, "R1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule